// File: doc/BRIEF.md
# Metering RMS and Power Calculator

This block turns three synchronised sample streams into the usual energy-metering figures. Each beat carries a signed voltage sample, a signed current sample, and a voltage sample that has already been shifted by 90 degrees upstream. Over a window of N accepted beats it sums four products: voltage squared, current squared, voltage times current, and shifted voltage times current. When the window closes it derives the RMS voltage, the RMS current, active power P, reactive power Q, apparent power S and the power factor PF.

The arithmetic is time-shared. A single multiply-accumulate unit handles the four per-beat products and later forms P squared plus Q squared. A single bit-serial square-root unit produces both RMS values and S. A single restoring divider produces PF. The stages follow one another with no path back into an earlier stage. N is a power of two, so each mean is an arithmetic right shift. Four programmable offsets are subtracted from the means before the roots and before P and Q leave the block.

Sample intake uses a valid/ready handshake. A beat is taken on a rising edge where both are high. The producer must hold a beat stable while ready is low. Ready drops for four cycles after every accepted beat while the products are formed. It stays low from the N-th beat until the results are published. The results are not back-pressured: they appear with a one-cycle strobe and hold until the next strobe.

Top module: `mtr_meter`

## Requirements
- R1: A beat is consumed only on a rising edge with `in_valid` and `in_ready` both high. `in_ready` is low in the cycle after each accepted beat. It stays low from the N-th accepted beat of a window until the cycle in which `res_valid` is high.
- R2: `vrms` equals floor(sqrt(max(0, floor(sum(v*v)/N) - `off_v`))). `irms` is formed the same way from the current samples and `off_i`. A negative difference gives 0.
- R3: `p_out` equals floor(sum(v*i)/N) - `off_p`, saturated to the signed 2*DW-bit range. The floor is taken toward minus infinity.
- R4: `q_out` is formed exactly like `p_out`, using the shifted voltage `in_vq` in place of `in_v` and using `off_q`.
- R5: `s_out` equals floor(sqrt(`p_out`^2 + `q_out`^2)), computed from the saturated P and Q.
- R6: `pf_out` is a signed fraction with FW fractional bits. It equals sign(P) * floor(|P| * 2^FW / S). When S is 0 it is 0 and no divide is started.
- R7: `res_valid` is high for exactly one cycle per window, after N accepted beats. The result outputs change only in that cycle and hold until the next one. Each window sums only its own N beats.
- R8: After reset, `in_ready` is 1, `res_valid` is 0 and every result output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample beat present |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_v | input | DW | Signed voltage sample |
| in_vq | input | DW | Signed 90-degree-shifted voltage sample |
| in_i | input | DW | Signed current sample |
| off_v | input | 2*DW | Unsigned offset subtracted from mean voltage square |
| off_i | input | 2*DW | Unsigned offset subtracted from mean current square |
| off_p | input | 2*DW | Signed offset subtracted from active power |
| off_q | input | 2*DW | Signed offset subtracted from reactive power |
| res_valid | output | 1 | One-cycle strobe: new results on the outputs |
| vrms | output | DW | RMS voltage |
| irms | output | DW | RMS current |
| p_out | output | 2*DW | Signed active power |
| q_out | output | 2*DW | Signed reactive power |
| s_out | output | 2*DW+1 | Apparent power |
| pf_out | output | FW+2 | Signed power factor, FW fractional bits |

## Verification
The bench sweeps many windows of pseudo-random samples, with idle gaps and an occasional full-scale value. It targets three corner cases, each caught at the ports:
- An all-zero window: a design that divides by zero would return a junk power factor instead of 0.
- An offset larger than the mean square: a design that misses the clamp would wrap the radicand and report a huge RMS value.
- A power offset that pushes P and Q beyond their range: a design without saturation would wrap the sign, and S and PF would come out wrong.

Ready is sampled after every accepted beat and throughout the finishing sequence. A design that swallowed a held beat twice, or that let the previous window leak into the next, would produce sums that no longer match the arithmetic model.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

  typedef enum logic [3:0] {
    ST_LOAD,
    ST_MAC,
    ST_MEAN,
    ST_SQV_GO,
    ST_SQV,
    ST_SQI,
    ST_PP,
    ST_QQ,
    ST_SQS_GO,
    ST_SQS,
    ST_DIV,
    ST_DONE
  } mtr_state_e;

  localparam int NACC   = 4;
  localparam int ACC_VV = 0;
  localparam int ACC_II = 1;
  localparam int ACC_VI = 2;
  localparam int ACC_QI = 3;

endpackage

// File: rtl/mtr_mac.sv
module mtr_mac #(
  parameter int OW   = 16,
  parameter int NACC = 4,
  localparam int ACW = 2 * OW + 1,
  localparam int SW  = $clog2(NACC)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  load,
  input  logic [SW-1:0]         sel,
  input  logic signed [OW-1:0]  op_a,
  input  logic signed [OW-1:0]  op_b,
  output logic signed [ACW-1:0] acc_o [NACC]
);

  logic signed [2*OW-1:0] prod;
  logic signed [ACW-1:0]  prod_x;

  assign prod   = op_a * op_b;
  assign prod_x = {prod[2*OW-1], prod};

  for (genvar g = 0; g < NACC; g++) begin : g_acc
    logic signed [ACW-1:0] acc_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_r <= '0;
      end else if (en && (sel == SW'(g))) begin
        acc_r <= load ? prod_x : (acc_r + prod_x);
      end
    end
    assign acc_o[g] = acc_r;
  end

endmodule

// File: rtl/mtr_isqrt.sv
module mtr_isqrt #(
  parameter int RW  = 34,
  localparam int QW = RW / 2,
  localparam int CW = $clog2(QW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [RW-1:0] radicand,
  output logic          done,
  output logic [QW-1:0] root
);

  logic [RW-1:0]   rad_q;
  logic [QW+1:0]   rem_q;
  logic [QW-1:0]   root_q;
  logic [CW-1:0]   cnt_q;
  logic            busy_q;
  logic            done_q;
  logic [QW+1:0]   rem_sh;
  logic [QW+1:0]   trial;
  logic            fits;

  assign rem_sh = (rem_q << 2) | {{QW{1'b0}}, rad_q[RW-1:RW-2]};
  assign trial  = {root_q, 2'b01};
  assign fits   = (rem_sh >= trial);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rad_q  <= '0;
      rem_q  <= '0;
      root_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        rad_q  <= radicand;
        rem_q  <= '0;
        root_q <= '0;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rad_q  <= rad_q << 2;
        rem_q  <= fits ? (rem_sh - trial) : rem_sh;
        root_q <= {root_q[QW-2:0], fits};
        cnt_q  <= cnt_q + 1'b1;
        if (cnt_q == CW'(QW - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign root = root_q;

endmodule

// File: rtl/mtr_udiv.sv
module mtr_udiv #(
  parameter int NW  = 24,
  parameter int DVW = 17,
  parameter int QOW = 10,
  localparam int CW = $clog2(NW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [NW-1:0]  dividend,
  input  logic [DVW-1:0] divisor,
  output logic           done,
  output logic [QOW-1:0] quotient
);

  logic [NW-1:0]  num_q;
  logic [DVW-1:0] den_q;
  logic [DVW:0]   rem_q;
  logic [QOW-1:0] quo_q;
  logic [CW-1:0]  cnt_q;
  logic           busy_q;
  logic           done_q;
  logic [DVW:0]   rem_sh;
  logic           fits;

  assign rem_sh = (rem_q << 1) | {{DVW{1'b0}}, num_q[NW-1]};
  assign fits   = (rem_sh >= {1'b0, den_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        num_q  <= dividend;
        den_q  <= divisor;
        rem_q  <= '0;
        quo_q  <= '0;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        num_q <= num_q << 1;
        rem_q <= fits ? (rem_sh - {1'b0, den_q}) : rem_sh;
        quo_q <= {quo_q[QOW-2:0], fits};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(NW - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done     = done_q;
  assign quotient = quo_q;

endmodule

// File: rtl/mtr_meter.sv
module mtr_meter
  import mtr_pkg::*;
#(
  parameter int DW    = 8,
  parameter int LOG2N = 4,
  parameter int FW    = 8,
  localparam int OW   = 2 * DW,
  localparam int QW   = 2 * DW + 1,
  localparam int PW   = FW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_v,
  input  logic signed [DW-1:0] in_vq,
  input  logic signed [DW-1:0] in_i,
  input  logic [OW-1:0]        off_v,
  input  logic [OW-1:0]        off_i,
  input  logic signed [OW-1:0] off_p,
  input  logic signed [OW-1:0] off_q,
  output logic                 res_valid,
  output logic [DW-1:0]        vrms,
  output logic [DW-1:0]        irms,
  output logic signed [OW-1:0] p_out,
  output logic signed [OW-1:0] q_out,
  output logic [QW-1:0]        s_out,
  output logic signed [PW-1:0] pf_out
);

  localparam int ACW = 2 * OW + 1;
  localparam int RW  = ACW + 1;
  localparam int NW  = OW + FW;
  localparam int SW  = $clog2(NACC);
  localparam int N   = 1 << LOG2N;
  localparam logic signed [ACW:0] PMAX = {{(ACW + 2 - OW){1'b0}}, {(OW - 1){1'b1}}};
  localparam logic signed [ACW:0] PMIN = {{(ACW + 2 - OW){1'b1}}, {(OW - 1){1'b0}}};

  mtr_state_e state_q;
  logic [1:0]        step_q;
  logic [LOG2N-1:0]  cnt_q;
  logic signed [DW-1:0] v_q, vq_q, i_q;
  logic [OW-1:0]     msv_q, msi_q;
  logic signed [OW-1:0] p_q, q_q;
  logic [DW-1:0]     vr_q, ir_q;
  logic [QW-1:0]     s_q;
  logic signed [PW-1:0] pf_q;

  // shared datapath controls
  logic                  mac_en, mac_load;
  logic [SW-1:0]         mac_sel;
  logic signed [OW-1:0]  mac_a, mac_b;
  logic signed [ACW-1:0] acc [NACC];
  logic                  sq_start, sq_done;
  logic [RW-1:0]         sq_rad;
  logic [QW-1:0]         sq_root;
  logic                  dv_start, dv_done;
  logic [PW-1:0]         dv_quo;
  logic [OW-1:0]         p_mag;
  logic signed [PW-1:0]  pf_val;
  logic signed [ACW-1:0] mean_vv, mean_ii, mean_vi, mean_qi;

  function automatic logic signed [OW-1:0] sx(input logic signed [DW-1:0] x);
    return {{(OW - DW){x[DW-1]}}, x};
  endfunction

  function automatic logic [OW-1:0] ms_sub(input logic signed [ACW-1:0] m,
                                          input logic [OW-1:0] off);
    logic signed [ACW:0] d;
    d = {m[ACW-1], m} - {{(ACW + 1 - OW){1'b0}}, off};
    if (d < 0) return '0;
    return d[OW-1:0];
  endfunction

  function automatic logic signed [OW-1:0] pw_sub(input logic signed [ACW-1:0] m,
                                                 input logic signed [OW-1:0] off);
    logic signed [ACW:0] d;
    d = {m[ACW-1], m} - {{(ACW + 1 - OW){off[OW-1]}}, off};
    if (d > PMAX) d = PMAX;
    if (d < PMIN) d = PMIN;
    return d[OW-1:0];
  endfunction

  assign mean_vv = acc[ACC_VV] >>> LOG2N;
  assign mean_ii = acc[ACC_II] >>> LOG2N;
  assign mean_vi = acc[ACC_VI] >>> LOG2N;
  assign mean_qi = acc[ACC_QI] >>> LOG2N;

  assign in_ready = (state_q == ST_LOAD);
  assign p_mag    = p_q[OW-1] ? (~p_q + 1'b1) : p_q;
  assign pf_val   = p_q[OW-1] ? (~dv_quo + 1'b1) : dv_quo;

  always_comb begin
    mac_en   = 1'b0;
    mac_load = 1'b0;
    mac_sel  = '0;
    mac_a    = '0;
    mac_b    = '0;
    sq_start = 1'b0;
    sq_rad   = '0;
    dv_start = 1'b0;
    case (state_q)
      ST_MAC: begin
        mac_en   = 1'b1;
        mac_load = (cnt_q == '0);
        case (step_q)
          2'd0: begin mac_sel = SW'(ACC_VV); mac_a = sx(v_q);  mac_b = sx(v_q); end
          2'd1: begin mac_sel = SW'(ACC_II); mac_a = sx(i_q);  mac_b = sx(i_q); end
          2'd2: begin mac_sel = SW'(ACC_VI); mac_a = sx(v_q);  mac_b = sx(i_q); end
          default: begin mac_sel = SW'(ACC_QI); mac_a = sx(vq_q); mac_b = sx(i_q); end
        endcase
      end
      ST_PP: begin
        mac_en   = 1'b1;
        mac_load = 1'b1;
        mac_sel  = SW'(ACC_VV);
        mac_a    = p_q;
        mac_b    = p_q;
      end
      ST_QQ: begin
        mac_en  = 1'b1;
        mac_sel = SW'(ACC_VV);
        mac_a   = q_q;
        mac_b   = q_q;
      end
      ST_SQV_GO: begin
        sq_start = 1'b1;
        sq_rad   = {{(RW - OW){1'b0}}, msv_q};
      end
      ST_SQV: begin
        sq_start = sq_done;
        sq_rad   = {{(RW - OW){1'b0}}, msi_q};
      end
      ST_SQS_GO: begin
        sq_start = 1'b1;
        sq_rad   = {1'b0, acc[ACC_VV]};
      end
      ST_SQS: begin
        dv_start = sq_done && (sq_root != '0);
      end
      default: ;
    endcase
  end

  mtr_mac #(.OW(OW), .NACC(NACC)) u_mac (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (mac_en),
    .load  (mac_load),
    .sel   (mac_sel),
    .op_a  (mac_a),
    .op_b  (mac_b),
    .acc_o (acc)
  );

  mtr_isqrt #(.RW(RW)) u_sqrt (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (sq_start),
    .radicand (sq_rad),
    .done     (sq_done),
    .root     (sq_root)
  );

  mtr_udiv #(.NW(NW), .DVW(QW), .QOW(PW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (dv_start),
    .dividend ({p_mag, {FW{1'b0}}}),
    .divisor  (sq_root),
    .done     (dv_done),
    .quotient (dv_quo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_LOAD;
      step_q    <= '0;
      cnt_q     <= '0;
      v_q       <= '0;
      vq_q      <= '0;
      i_q       <= '0;
      msv_q     <= '0;
      msi_q     <= '0;
      p_q       <= '0;
      q_q       <= '0;
      vr_q      <= '0;
      ir_q      <= '0;
      s_q       <= '0;
      pf_q      <= '0;
      res_valid <= 1'b0;
      vrms      <= '0;
      irms      <= '0;
      p_out     <= '0;
      q_out     <= '0;
      s_out     <= '0;
      pf_out    <= '0;
    end else begin
      res_valid <= 1'b0;
      case (state_q)
        ST_LOAD: begin
          if (in_valid) begin
            v_q     <= in_v;
            vq_q    <= in_vq;
            i_q     <= in_i;
            step_q  <= '0;
            state_q <= ST_MAC;
          end
        end
        ST_MAC: begin
          step_q <= step_q + 1'b1;
          if (step_q == 2'd3) begin
            if (cnt_q == LOG2N'(N - 1)) begin
              cnt_q   <= '0;
              state_q <= ST_MEAN;
            end else begin
              cnt_q   <= cnt_q + 1'b1;
              state_q <= ST_LOAD;
            end
          end
        end
        ST_MEAN: begin
          msv_q   <= ms_sub(mean_vv, off_v);
          msi_q   <= ms_sub(mean_ii, off_i);
          p_q     <= pw_sub(mean_vi, off_p);
          q_q     <= pw_sub(mean_qi, off_q);
          state_q <= ST_SQV_GO;
        end
        ST_SQV_GO: state_q <= ST_SQV;
        ST_SQV: begin
          if (sq_done) begin
            vr_q    <= sq_root[DW-1:0];
            state_q <= ST_SQI;
          end
        end
        ST_SQI: begin
          if (sq_done) begin
            ir_q    <= sq_root[DW-1:0];
            state_q <= ST_PP;
          end
        end
        ST_PP:     state_q <= ST_QQ;
        ST_QQ:     state_q <= ST_SQS_GO;
        ST_SQS_GO: state_q <= ST_SQS;
        ST_SQS: begin
          if (sq_done) begin
            s_q <= sq_root;
            if (sq_root == '0) begin
              pf_q    <= '0;
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_DIV;
            end
          end
        end
        ST_DIV: begin
          if (dv_done) begin
            pf_q    <= pf_val;
            state_q <= ST_DONE;
          end
        end
        ST_DONE: begin
          res_valid <= 1'b1;
          vrms      <= vr_q;
          irms      <= ir_q;
          p_out     <= p_q;
          q_out     <= q_q;
          s_out     <= s_q;
          pf_out    <= pf_q;
          state_q   <= ST_LOAD;
        end
        default: state_q <= ST_LOAD;
      endcase
    end
  end

endmodule

// File: rtl/mtr_meter_chk.sv
module mtr_meter_chk #(
  parameter int DW    = 8,
  parameter int LOG2N = 4,
  parameter int FW    = 8,
  localparam int OW   = 2 * DW,
  localparam int QW   = 2 * DW + 1,
  localparam int PW   = FW + 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 res_valid,
  input logic [DW-1:0]        vrms,
  input logic [DW-1:0]        irms,
  input logic signed [OW-1:0] p_out,
  input logic signed [OW-1:0] q_out,
  input logic [QW-1:0]        s_out,
  input logic signed [PW-1:0] pf_out
);

  localparam int N = 1 << LOG2N;
  localparam logic [DW-1:0]        RMAX  = DW'(1 << (DW - 1));
  localparam logic signed [PW-1:0] PFMAX = PW'(1 << FW);
  localparam logic signed [PW-1:0] PFMIN = -PFMAX;

  logic [LOG2N:0] beats_q;
  logic [OW-1:0]  pmag;
  logic           fire;

  assign fire = in_valid && in_ready;
  assign pmag = p_out[OW-1] ? (~p_out + 1'b1) : p_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         beats_q <= '0;
    else if (res_valid) beats_q <= fire ? (LOG2N + 1)'(1) : '0;
    else if (fire)      beats_q <= beats_q + 1'b1;
  end

  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R7
  AST_WINDOW_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (beats_q == (LOG2N + 1)'(N))); // R7
  AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable({vrms, irms, p_out, q_out, s_out, pf_out})); // R7
  AST_READY_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !in_ready); // R1
  AST_FULL_WINDOW_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ((beats_q == (LOG2N + 1)'(N)) && !res_valid) |-> !in_ready); // R1
  AST_RMS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (vrms <= RMAX) && (irms <= RMAX)); // R2
  AST_S_COVERS_P: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (s_out >= {{(QW - OW){1'b0}}, pmag})); // R5
  AST_PF_ZERO_S: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (s_out == '0)) |-> (pf_out == '0)); // R6
  AST_PF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((pf_out <= PFMAX) && (pf_out >= PFMIN))); // R6

endmodule

bind mtr_meter mtr_meter_chk #(.DW(DW), .LOG2N(LOG2N), .FW(FW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .res_valid (res_valid),
  .vrms      (vrms),
  .irms      (irms),
  .p_out     (p_out),
  .q_out     (q_out),
  .s_out     (s_out),
  .pf_out    (pf_out)
);

// File: tb/mtr_meter_tb_top.sv
module mtr_meter_tb_top;

  localparam int DW    = 8;
  localparam int LOG2N = 2;
  localparam int FW    = 8;
  localparam int N     = 1 << LOG2N;
  localparam int OW    = 2 * DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [DW-1:0] in_v = '0, in_vq = '0, in_i = '0;
  logic [OW-1:0] off_v = '0, off_i = '0;
  logic signed [OW-1:0] off_p = '0, off_q = '0;
  logic res_valid;
  logic [DW-1:0] vrms, irms;
  logic signed [OW-1:0] p_out, q_out;
  logic [OW:0] s_out;
  logic signed [FW+1:0] pf_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;
  bit gaps = 0;
  int unsigned seed = 32'h1234_5678;

  logic signed [DW-1:0] bv [N];
  logic signed [DW-1:0] bq [N];
  logic signed [DW-1:0] bi [N];
  longint e_vr, e_ir, e_p, e_q, e_s, e_pf;

  always #4 clk = ~clk;

  mtr_meter #(.DW(DW), .LOG2N(LOG2N), .FW(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_v(in_v), .in_vq(in_vq), .in_i(in_i),
    .off_v(off_v), .off_i(off_i), .off_p(off_p), .off_q(off_q),
    .res_valid(res_valid), .vrms(vrms), .irms(irms), .p_out(p_out),
    .q_out(q_out), .s_out(s_out), .pf_out(pf_out)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint isqrt(input longint x);
    longint r = 0;
    for (int b = 24; b >= 0; b--) begin
      longint t = r + (longint'(1) << b);
      if (t * t <= x) r = t;
    end
    return r;
  endfunction

  function automatic longint sat(input longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  function automatic int unsigned rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic expect_window();
    longint svv = 0, sii = 0, svi = 0, sqi = 0, msv, msi, mag;
    for (int k = 0; k < N; k++) begin
      svv += longint'(bv[k]) * longint'(bv[k]);
      sii += longint'(bi[k]) * longint'(bi[k]);
      svi += longint'(bv[k]) * longint'(bi[k]);
      sqi += longint'(bq[k]) * longint'(bi[k]);
    end
    msv = (svv >>> LOG2N) - longint'(off_v);
    msi = (sii >>> LOG2N) - longint'(off_i);
    if (msv < 0) msv = 0;
    if (msi < 0) msi = 0;
    e_vr = isqrt(msv);
    e_ir = isqrt(msi);
    e_p  = sat((svi >>> LOG2N) - longint'(off_p));
    e_q  = sat((sqi >>> LOG2N) - longint'(off_q));
    e_s  = isqrt(e_p * e_p + e_q * e_q);
    if (e_s == 0) e_pf = 0;
    else begin
      mag  = (e_p < 0) ? -e_p : e_p;
      e_pf = ((mag << FW) / e_s);
      if (e_p < 0) e_pf = -e_pf;
    end
  endtask

  task automatic run_window(input string tag);
    int wait_cnt;
    bit ready_leak;
    @(negedge clk);
    for (int k = 0; k < N; k++) begin
      if (gaps && (rnd() % 3 == 0)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_v = bv[k]; in_vq = bq[k]; in_i = bi[k];
      in_valid = 1'b1;
      while (in_ready !== 1'b1) @(negedge clk);
      @(negedge clk);
      check("R1", {tag, " ready low after beat"}, longint'(in_ready), 0);
      in_valid = 1'b0;
    end
    expect_window();
    wait_cnt = 0;
    ready_leak = 0;
    while (res_valid !== 1'b1 && wait_cnt < 2000) begin
      if (in_ready !== 1'b0) ready_leak = 1;
      in_valid = 1'b1;
      @(negedge clk);
      wait_cnt++;
    end
    in_valid = 1'b0;
    check("R1", {tag, " ready stays low until results"}, longint'(ready_leak), 0);
    check("R7", {tag, " result strobe seen"}, longint'(res_valid), 1);
    check("R2", {tag, " vrms"}, longint'(vrms), e_vr);
    check("R2", {tag, " irms"}, longint'(irms), e_ir);
    check("R3", {tag, " p_out"}, longint'(p_out), e_p);
    check("R4", {tag, " q_out"}, longint'(q_out), e_q);
    check("R5", {tag, " s_out"}, longint'(s_out), e_s);
    check("R6", {tag, " pf_out"}, longint'(pf_out), e_pf);
    check("R1", {tag, " ready back with strobe"}, longint'(in_ready), 1);
    @(negedge clk);
    check("R7", {tag, " strobe one cycle"}, longint'(res_valid), 0);
    check("R7", {tag, " results hold"},
          longint'((vrms == e_vr[DW-1:0]) && (p_out == e_p[OW-1:0]) && (s_out == e_s[OW:0]) &&
                   (pf_out == e_pf[FW+1:0]) && (irms == e_ir[DW-1:0]) && (q_out == e_q[OW-1:0])), 1);
  endtask

  task automatic fill(input int v, input int q, input int i);
    for (int k = 0; k < N; k++) begin
      bv[k] = DW'(v); bq[k] = DW'(q); bi[k] = DW'(i);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      errors++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", "ready after reset", longint'(in_ready), 1);
    check("R8", "no strobe after reset", longint'(res_valid), 0);
    check("R8", "outputs zero after reset",
          longint'(vrms) + longint'(irms) + longint'(p_out) + longint'(q_out) +
          longint'(s_out) + longint'(pf_out), 0);

    fill(0, 0, 0);           run_window("zero window, PF forced 0");
    fill(100, 0, 50);        run_window("constant in-phase");
    fill(-128, -128, -128);  run_window("full negative scale");
    off_v = 16'd20000;       run_window("voltage offset clamp");
    off_v = '0;
    fill(-128, 127, 127);
    off_p = 16'sd32767; off_q = -16'sd32768;
    run_window("power saturation");
    off_p = '0; off_q = '0;
    bv[0] = 8'sd3; bv[1] = -8'sd1; bv[2] = 8'sd0; bv[3] = 8'sd0;
    bq[0] = 8'sd0; bq[1] = -8'sd3; bq[2] = 8'sd0; bq[3] = 8'sd0;
    bi[0] = -8'sd1; bi[1] = 8'sd1; bi[2] = 8'sd0; bi[3] = 8'sd0;
    run_window("floor toward minus infinity");

    gaps = 1;
    for (int w = 0; w < 200; w++) begin
      for (int k = 0; k < N; k++) begin
        bv[k] = DW'(rnd()); bq[k] = DW'(rnd()); bi[k] = DW'(rnd());
        if (w % 10 == 3) begin bv[k] = -8'sd128; bi[k] = 8'sd127; end
      end
      off_v = OW'(rnd() % 2048);
      off_i = OW'(rnd() % 2048);
      off_p = OW'(int'(rnd() % 4096) - 2048);
      off_q = OW'(int'(rnd() % 4096) - 2048);
      run_window("random sweep");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule